// File: doc/BRIEF.md
# Fast GPIO Port with Set/Clear/Toggle Aliases

This block is a 16-pin general-purpose I/O port on a simple memory-mapped bus. Its 16-byte register window is decoded one way for stores and another way for loads. A single store can set, clear or invert chosen output bits, so software never needs a read-modify-write sequence.

A direction register and a pin-enable register decide which pins are driven. A data latch supplies the value driven onto output pins. Input pins pass through a two-stage synchronizer, and their levels appear in the data read-back. The pin side uses tri-state style controls: output value, output enable and input sample.

The bus carries a word address (bits 3:2 of the byte offset), four byte enables and 32-bit data. Every request gets a response one cycle later, with ready high and no error path.

Top module: `fgpio_port`

## Requirements
- R1: After reset, the direction, data latch and pin-enable registers are 0x0000, so `pin_oe` and `pin_out` are 0 and ready is low.
- R2: A write to word 0 updates direction from bits 31:16 and the data latch from bits 15:0. A write to word 1 updates pin enable from bits 31:16. Each byte enable updates only its own byte, big-endian: `req_be[3]`=bits 31:24, `req_be[2]`=23:16, `req_be[1]`=15:8, `req_be[0]`=7:0.
- R3: A write to word 1, bits 15:0 (offset 0x6) clears each data-latch bit that is 1 in the enabled bytes. Other bits stay unchanged.
- R4: A write to word 2, bits 15:0 (offset 0xA) sets each data-latch bit that is 1 in the enabled bytes.
- R5: A write to word 3, bits 15:0 (offset 0xE) inverts each data-latch bit that is 1 in the enabled bytes.
- R6: Writes to bits 31:16 of words 2 and 3 (offsets 0x8 and 0xC) complete normally and change no register.
- R7: A read returns pin enable in bits 31:16 for word 1 and direction in bits 31:16 for words 0, 2 and 3. Bits 15:0 always hold the data read-back.
- R8: `pin_oe` bit i is 1 exactly when both enable bit i and direction bit i are 1. `pin_out` shows the data latch.
- R9: For a direction-0 pin, data read-back bit i shows `pin_in` bit i through two synchronizer flops. For a direction-1 pin, it shows latch bit i.
- R10: `rsp_ready` is high in the cycle after each request and low otherwise. `rsp_rdata` holds the read value in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_word | input | 2 | Word address (byte offset bits 3:2) |
| req_be | input | 4 | Byte enables, big-endian lanes |
| req_wdata | input | 32 | Store data |
| rsp_ready | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Load data |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |

## Verification
The checker watches, on every cycle, the response timing and the effect of each full-halfword clear, set and toggle alias store on the latch. It also checks that stores to the two void slots leave every register stable. Three properties depend on a chosen stimulus, so only the bench's sweeps can show them: the byte-lane merge under each of the sixteen byte-enable patterns, the read aliasing of all four words, and the exact two-cycle delay through the input synchronizer.

// File: rtl/fgpio_pkg.sv
package fgpio_pkg;
  localparam int REG_W = 16;

  // Merge a 16-bit write into old contents; be2[1] selects bits 15:8.
  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] wr_v,
                                                  input logic [1:0] be2);
    logic [REG_W-1:0] keep;
    keep = {{8{~be2[1]}}, {8{~be2[0]}}};
    return (old_v & keep) | (wr_v & ~keep);
  endfunction

  // Bits selected for an alias operation: write ones in enabled bytes.
  function automatic logic [REG_W-1:0] lane_mask(input logic [REG_W-1:0] wr_v,
                                                 input logic [1:0] be2);
    return wr_v & {{8{be2[1]}}, {8{be2[0]}}};
  endfunction

  // Read-back: latch for outputs, synchronized pin for inputs.
  function automatic logic [REG_W-1:0] data_view(input logic [REG_W-1:0] dir_v,
                                                 input logic [REG_W-1:0] latch_v,
                                                 input logic [REG_W-1:0] pin_v);
    return (dir_v & latch_v) | (~dir_v & pin_v);
  endfunction
endpackage

// File: rtl/fgpio_sync.sv
module fgpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[s] <= '0;
          else     st[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[s] <= '0;
          else     st[s] <= st[s-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/fgpio_regs.sv
module fgpio_regs
  import fgpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       word,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] enb_q,
  output logic             wr_clr,
  output logic             wr_set,
  output logic             wr_tog,
  output logic             wr_void
);
  logic [1:0]       hi_be, lo_be;
  logic [REG_W-1:0] hi_d, lo_d, lo_mask;
  logic             hi_any, lo_any;
  logic             wr_dir, wr_data, wr_enb;

  assign hi_be   = be[3:2];
  assign lo_be   = be[1:0];
  assign hi_d    = wdata[31:16];
  assign lo_d    = wdata[15:0];
  assign hi_any  = |hi_be;
  assign lo_any  = |lo_be;
  assign lo_mask = lane_mask(lo_d, lo_be);

  assign wr_dir  = wr_en && (word == 2'd0) && hi_any;
  assign wr_data = wr_en && (word == 2'd0) && lo_any;
  assign wr_enb  = wr_en && (word == 2'd1) && hi_any;
  assign wr_clr  = wr_en && (word == 2'd1) && lo_any;
  assign wr_set  = wr_en && (word == 2'd2) && lo_any;
  assign wr_tog  = wr_en && (word == 2'd3) && lo_any;
  assign wr_void = wr_en && word[1] && hi_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      enb_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= lane_merge(dir_q, hi_d, hi_be);
      if (wr_enb) enb_q <= lane_merge(enb_q, hi_d, hi_be);
      if (wr_data)     data_q <= lane_merge(data_q, lo_d, lo_be);
      else if (wr_clr) data_q <= data_q & ~lo_mask;
      else if (wr_set) data_q <= data_q | lo_mask;
      else if (wr_tog) data_q <= data_q ^ lo_mask;
    end
  end
endmodule

// File: rtl/fgpio_rdmux.sv
module fgpio_rdmux
  import fgpio_pkg::*;
(
  input  logic [1:0]       word,
  input  logic [REG_W-1:0] dir_q,
  input  logic [REG_W-1:0] data_q,
  input  logic [REG_W-1:0] enb_q,
  input  logic [REG_W-1:0] pin_sync,
  output logic [31:0]      rd_word
);
  logic [REG_W-1:0] hi_v;

  always_comb begin
    hi_v = (word == 2'd1) ? enb_q : dir_q;
    rd_word = {hi_v, data_view(dir_q, data_q, pin_sync)};
  end
endmodule

// File: rtl/fgpio_port.sv
module fgpio_port
  import fgpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_word,
  input  logic [3:0]       req_be,
  input  logic [31:0]      req_wdata,
  output logic             rsp_ready,
  output logic [31:0]      rsp_rdata,
  input  logic [REG_W-1:0] pin_in,
  output logic [REG_W-1:0] pin_out,
  output logic [REG_W-1:0] pin_oe
);
  logic [REG_W-1:0] dir_q, data_q, enb_q, pin_sync;
  logic             wr_clr, wr_set, wr_tog, wr_void;
  logic [31:0]      rd_word;
  logic             wr_en;

  assign wr_en = req_valid && req_write;

  fgpio_sync #(.W(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  fgpio_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .word(req_word), .be(req_be),
    .wdata(req_wdata), .dir_q(dir_q), .data_q(data_q), .enb_q(enb_q),
    .wr_clr(wr_clr), .wr_set(wr_set), .wr_tog(wr_tog), .wr_void(wr_void)
  );

  fgpio_rdmux u_rd (
    .word(req_word), .dir_q(dir_q), .data_q(data_q), .enb_q(enb_q),
    .pin_sync(pin_sync), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      if (req_valid && !req_write) rsp_rdata <= rd_word;
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = enb_q & dir_q;
endmodule

// File: rtl/fgpio_chk.sv
module fgpio_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [1:0]  req_be_lo,
  input logic [15:0] req_wdata_lo,
  input logic        rsp_ready,
  input logic        wr_clr,
  input logic        wr_set,
  input logic        wr_tog,
  input logic        wr_void,
  input logic [15:0] dir_q,
  input logic [15:0] data_q,
  input logic [15:0] enb_q
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_ready);
  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_ready);
  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && req_be_lo == 2'b11) |=> ((data_q & $past(req_wdata_lo)) == 16'h0));
  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_set && req_be_lo == 2'b11) |=> ((data_q & $past(req_wdata_lo)) == $past(req_wdata_lo)));
  // R5
  tog_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_tog && req_be_lo == 2'b11) |=> (data_q == ($past(data_q) ^ $past(req_wdata_lo))));
  // R6
  void_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_void && !wr_set && !wr_tog) |=> ($stable(dir_q) && $stable(data_q) && $stable(enb_q)));
endmodule

bind fgpio_port fgpio_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_be_lo(req_be[1:0]),
  .req_wdata_lo(req_wdata[15:0]), .rsp_ready(rsp_ready),
  .wr_clr(wr_clr), .wr_set(wr_set), .wr_tog(wr_tog), .wr_void(wr_void),
  .dir_q(dir_q), .data_q(data_q), .enb_q(enb_q)
);

// File: tb/sim_fgpio_port.sv
module sim_fgpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_word;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic [15:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] m_dir, m_data, m_enb, m_pin;
  logic [31:0] lfsr;

  fgpio_port u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model of one byte lane update: lane index 1 is bits 15:8.
  function automatic logic [15:0] put_bytes(input logic [15:0] old_v, input logic [15:0] v,
                                            input logic [1:0] en);
    logic [15:0] r = old_v;
    for (int b = 0; b < 2; b++)
      if (en[b]) r[b*8 +: 8] = v[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [15:0] sel_bits(input logic [15:0] v, input logic [1:0] en);
    return put_bytes(16'h0000, v, en);
  endfunction

  function automatic logic [15:0] view(input logic [15:0] pins);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = m_dir[i] ? m_data[i] : pins[i];
    return r;
  endfunction

  task automatic model_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    case (w)
      2'd0: begin
        m_dir  = put_bytes(m_dir, d[31:16], be[3:2]);
        m_data = put_bytes(m_data, d[15:0], be[1:0]);
      end
      2'd1: begin
        m_enb  = put_bytes(m_enb, d[31:16], be[3:2]);
        m_data = m_data & ~sel_bits(d[15:0], be[1:0]);
      end
      2'd2: m_data = m_data | sel_bits(d[15:0], be[1:0]);
      default: m_data = m_data ^ sel_bits(d[15:0], be[1:0]);
    endcase
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic bus_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_word = w; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(w, be, d);
  endtask

  task automatic bus_read(input logic [1:0] w, output logic [31:0] d, output logic rdy);
    req_valid = 1'b1; req_write = 1'b0; req_word = w; req_be = 4'hF; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; rdy = rsp_ready;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    logic        rdy;
    for (int w = 0; w < 4; w++) begin
      bus_read(w[1:0], d, rdy);
      check(req, d, {(w == 1) ? m_enb : m_dir, view(m_pin)});
    end
    check("R8 oe", {16'h0, pin_oe}, {16'h0, m_enb & m_dir});
    check("R8 out", {16'h0, pin_out}, {16'h0, m_data});
  endtask

  initial begin
    logic [31:0] d;
    logic        rdy;
    rst = 1'b1; req_valid = 0; req_write = 0; req_word = 0; req_be = 0; req_wdata = 0;
    pin_in = 16'hA55A; m_pin = 16'hA55A;
    m_dir = 0; m_data = 0; m_enb = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 oe", {16'h0, pin_oe}, 32'h0);
    check("R1 out", {16'h0, pin_out}, 32'h0);
    check("R1 ready", {31'h0, rsp_ready}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_all("R1 R7 reset read");

    // R10: ready follows the request by one cycle, then drops
    bus_read(2'd0, d, rdy);
    check("R10 ready high", {31'h0, rdy}, 32'h1);
    @(negedge clk);
    check("R10 ready low", {31'h0, rsp_ready}, 32'h0);

    // R2: every byte-enable pattern on words 0 and 1
    lfsr = 32'h1BAD_C0DE;
    for (int be = 0; be < 16; be++) begin
      for (int w = 0; w < 2; w++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bus_write(w[1:0], be[3:0], lfsr);
        check_all("R2 R7 lane write");
      end
    end

    // R3 R4 R5 R6: alias and void-slot sweep with all byte-enable patterns
    for (int be = 0; be < 16; be++) begin
      for (int w = 1; w < 4; w++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        bus_write(w[1:0], be[3:0], {16'h0, lfsr[15:0]} | (w == 1 ? 32'h0 : {lfsr[31:16], 16'h0}));
        case (w)
          1: check_all("R3 clear alias");
          2: check_all("R4 R6 set alias / void slot");
          default: check_all("R5 R6 toggle alias / void slot");
        endcase
      end
    end

    // R6: pure void-slot stores at offsets 0x8 and 0xC
    bus_write(2'd2, 4'b1100, 32'hFFFF_0000);
    check_all("R6 void 0x8");
    bus_write(2'd3, 4'b1100, 32'hFFFF_0000);
    check_all("R6 void 0xC");

    // R9: two-flop input synchronizer on input pins
    bus_write(2'd0, 4'b1100, 32'h00FF_0000);   // low byte outputs, high byte inputs
    check_all("R9 setup");
    pin_in = 16'h5AA5;
    bus_read(2'd0, d, rdy);
    check("R9 stage1 old", {16'h0, d[15:0]}, {16'h0, view(m_pin)});
    bus_read(2'd0, d, rdy);
    check("R9 stage2 old", {16'h0, d[15:0]}, {16'h0, view(m_pin)});
    m_pin = 16'h5AA5;
    bus_read(2'd0, d, rdy);
    check("R9 new level", {16'h0, d[15:0]}, {16'h0, view(m_pin)});

    // R8: single-pin sweep of enable and direction
    for (int i = 0; i < 16; i++) begin
      bus_write(2'd0, 4'b1100, {16'h1 << i, 16'h0});
      bus_write(2'd1, 4'b1100, {16'hFFFF ^ (16'h1 << ((i + 1) % 16)), 16'h0});
      check("R8 oe sweep", {16'h0, pin_oe}, {16'h0, m_enb & m_dir});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule